// File: doc/BRIEF.md
# DSP Status and Condition Flag Unit

This block keeps the status register of a small fixed-point DSP datapath. When an instruction retires, the ALU presents four raw result flags: carry/borrow, negative, zero and overflow. The block also receives the instruction's class and whether the instruction is conditional. Only unconditional flag-producing DSP operations update the stored flags. Multiplies, data moves, CPU instructions and every conditional DSP instruction leave the register untouched.

A 3-bit select field in the register chooses one condition, and that condition is copied into a single decision bit, DC. DC is recomputed from the new flags on the same clock edge that loads them, so the next instruction already sees it. A conditional DSP instruction runs either "if DC is set" or "if DC is clear". The block gives the datapath a write-enable, so a DSP instruction whose condition fails writes no destination register. Software can read the register and write it. A software write wins over a retiring instruction in the same cycle.

Top module: `dsp_status_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole register: all flags, DC and the select field read 0.
- R2: Register layout on `sw_rdata` and `sw_wdata`:
  - bit 0 is DC
  - bit 1 is carry
  - bit 2 is negative
  - bit 3 is zero
  - bit 4 is overflow
  - bits 7:5 are the select field
- R3: A retiring instruction of class 2'b01 (flag-producing DSP operation) with `is_cond`=0 and no software write loads carry, negative, zero and overflow from `alu_c`, `alu_n`, `alu_z` and `alu_v` at the clock edge.
- R4: Select codes 0 to 3 pick carry, negative, zero and overflow. DC is taken from the newly loaded flags at the same edge that loads them.
- R5: Select code 4 gives signed greater-than, which is NOT(N XOR V) AND NOT Z. Select code 5 gives signed greater-or-equal, which is NOT(N XOR V).
- R6: Select codes 6 and 7 force DC to 0 whatever the flags are.
- R7: A retiring instruction of class 2'b10 (multiply or data move) leaves the register unchanged.
- R8: A retiring instruction of class 2'b00 (CPU) leaves the register unchanged, even when it is a multiply-accumulate.
- R9: A conditional DSP instruction never changes the register, whether it executes or not.
- R10: `wr_en` works as follows, in the same cycle as the retiring instruction:
  - With no instruction retiring, `wr_en` is 0.
  - For a retiring unconditional instruction, or for any CPU instruction, `wr_en` is 1.
  - For a conditional DSP instruction (class 2'b01 or 2'b10), `wr_en` is 1 exactly when DC equals `cond_sense`.
- R11: A software write loads the flags and the select field from `sw_wdata` and recomputes DC from them. Bit 0 of the write data is ignored. The software write wins over an instruction retiring in the same cycle.
- R12: With no retiring instruction and no software write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| instr_class | input | 2 | 00 CPU, 01 flag-producing DSP op, 10 DSP multiply/move, 11 no flag update |
| is_cond | input | 1 | The retiring instruction is conditional |
| cond_sense | input | 1 | Conditional polarity: 1 runs if DC=1, 0 runs if DC=0 |
| alu_c | input | 1 | ALU carry/borrow result |
| alu_n | input | 1 | ALU negative result |
| alu_z | input | 1 | ALU zero result |
| alu_v | input | 1 | ALU overflow result |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Current register contents |
| dc | output | 1 | Current condition bit |
| wr_en | output | 1 | Destination write enable for the retiring instruction |

## Verification
The main function is swept over all eight select codes against all sixteen combinations of the four raw flags. This tells apart:
- each plain flag from the others;
- the signed comparisons from a plain N or Z pick;
- the reserved codes from the valid ones.

The same-edge DC recomputation is checked by reading DC one cycle after the update. The hold cases present flag inputs that differ from the stored value, so a wrong load shows up. Those inputs come from multiply/move, CPU and conditional instructions and from idle cycles. For the write-enable, both polarities are driven with DC set and with DC clear. A CPU instruction that carries a stray conditional bit is also tried.

// File: rtl/dsp_status_pkg.sv
package dsp_status_pkg;

  localparam int SEL_W   = 3;
  localparam int FLAG_N  = 4;
  localparam int STAT_W  = SEL_W + FLAG_N + 1;

  typedef enum logic [1:0] {
    CLS_CPU        = 2'b00,
    CLS_DSP_ALU    = 2'b01,
    CLS_DSP_NOFLAG = 2'b10,
    CLS_NONE       = 2'b11
  } instr_class_e;

  localparam logic [SEL_W-1:0] SEL_CARRY = 3'd0;
  localparam logic [SEL_W-1:0] SEL_NEG   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ZERO  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_OVF   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SGT   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_SGE   = 3'd5;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             v;
    logic             z;
    logic             n;
    logic             c;
    logic             dc;
  } status_t;

endpackage

// File: rtl/dsp_cond_select.sv
module dsp_cond_select
  import dsp_status_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             c,
  input  logic             n,
  input  logic             z,
  input  logic             v,
  output logic             cond
);

  logic sge;

  assign sge = ~(n ^ v);

  always_comb begin
    unique case (sel)
      SEL_CARRY: cond = c;
      SEL_NEG:   cond = n;
      SEL_ZERO:  cond = z;
      SEL_OVF:   cond = v;
      SEL_SGT:   cond = sge & ~z;
      SEL_SGE:   cond = sge;
      default:   cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsp_wr_gate.sv
module dsp_wr_gate
  import dsp_status_pkg::*;
(
  input  logic         retire_valid,
  input  instr_class_e cls,
  input  logic         is_cond,
  input  logic         cond_sense,
  input  logic         dc,
  output logic         wr_en
);

  logic dsp_kind;

  assign dsp_kind = (cls == CLS_DSP_ALU) || (cls == CLS_DSP_NOFLAG);

  always_comb begin
    if (!retire_valid)
      wr_en = 1'b0;
    else if (dsp_kind && is_cond)
      wr_en = (dc == cond_sense);
    else
      wr_en = 1'b1;
  end

endmodule

// File: rtl/dsp_status_next.sv
module dsp_status_next
  import dsp_status_pkg::*;
(
  input  status_t             cur,
  input  logic                retire_valid,
  input  instr_class_e        cls,
  input  logic                is_cond,
  input  logic                alu_c,
  input  logic                alu_n,
  input  logic                alu_z,
  input  logic                alu_v,
  input  logic                sw_we,
  input  logic [STAT_W-1:0]   sw_wdata,
  output status_t             nxt,
  output logic                load
);

  status_t wr_view;

  assign wr_view = status_t'(sw_wdata);

  always_comb begin
    nxt  = cur;
    load = 1'b0;
    if (sw_we) begin
      nxt.sel = wr_view.sel;
      nxt.c   = wr_view.c;
      nxt.n   = wr_view.n;
      nxt.z   = wr_view.z;
      nxt.v   = wr_view.v;
      load    = 1'b1;
    end else if (retire_valid && (cls == CLS_DSP_ALU) && !is_cond) begin
      nxt.c = alu_c;
      nxt.n = alu_n;
      nxt.z = alu_z;
      nxt.v = alu_v;
      load  = 1'b1;
    end
  end

endmodule

// File: rtl/dsp_status_unit.sv
module dsp_status_unit
  import dsp_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_valid,
  input  logic [1:0]        instr_class,
  input  logic              is_cond,
  input  logic              cond_sense,
  input  logic              alu_c,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic              alu_v,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_wdata,
  output logic [STAT_W-1:0] sw_rdata,
  output logic              dc,
  output logic              wr_en
);

  instr_class_e cls;
  status_t      stat_q;
  status_t      stat_nxt;
  logic         load;
  logic         dc_nxt;

  assign cls = instr_class_e'(instr_class);

  dsp_status_next u_next (
    .cur          (stat_q),
    .retire_valid (retire_valid),
    .cls          (cls),
    .is_cond      (is_cond),
    .alu_c        (alu_c),
    .alu_n        (alu_n),
    .alu_z        (alu_z),
    .alu_v        (alu_v),
    .sw_we        (sw_we),
    .sw_wdata     (sw_wdata),
    .nxt          (stat_nxt),
    .load         (load)
  );

  // DC follows the flags being loaded, not the old ones
  dsp_cond_select u_sel (
    .sel  (stat_nxt.sel),
    .c    (stat_nxt.c),
    .n    (stat_nxt.n),
    .z    (stat_nxt.z),
    .v    (stat_nxt.v),
    .cond (dc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (load) begin
      stat_q.sel <= stat_nxt.sel;
      stat_q.v   <= stat_nxt.v;
      stat_q.z   <= stat_nxt.z;
      stat_q.n   <= stat_nxt.n;
      stat_q.c   <= stat_nxt.c;
      stat_q.dc  <= dc_nxt;
    end
  end

  dsp_wr_gate u_gate (
    .retire_valid (retire_valid),
    .cls          (cls),
    .is_cond      (is_cond),
    .cond_sense   (cond_sense),
    .dc           (stat_q.dc),
    .wr_en        (wr_en)
  );

  assign sw_rdata = stat_q;
  assign dc       = stat_q.dc;

endmodule

// File: rtl/dsp_status_checker.sv
module dsp_status_checker
  import dsp_status_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              retire_valid,
  input logic [1:0]        instr_class,
  input logic              is_cond,
  input logic              cond_sense,
  input logic              alu_c,
  input logic              alu_n,
  input logic              alu_z,
  input logic              alu_v,
  input logic              sw_we,
  input logic [STAT_W-1:0] sw_wdata,
  input logic [STAT_W-1:0] sw_rdata,
  input logic              dc,
  input logic              wr_en
);

  logic dsp_kind;
  assign dsp_kind = (instr_class == CLS_DSP_ALU) || (instr_class == CLS_DSP_NOFLAG);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> sw_rdata == '0);

  assert_alu_load_R3: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && instr_class == CLS_DSP_ALU && !is_cond && !sw_we) |=>
      sw_rdata[4:1] == {$past(alu_v), $past(alu_z), $past(alu_n), $past(alu_c)});

  assert_reserved_dc_R6: assert property (@(posedge clk) disable iff (rst)
    (sw_rdata[7:6] == 2'b11) |-> !dc);

  assert_noflag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && instr_class == CLS_DSP_NOFLAG && !sw_we) |=> $stable(sw_rdata));

  assert_cpu_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && instr_class == CLS_CPU && !sw_we) |=> $stable(sw_rdata));

  assert_cond_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && dsp_kind && is_cond && !sw_we) |=> $stable(sw_rdata));

  assert_uncond_enable_R10: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && (!is_cond || instr_class == CLS_CPU)) |-> wr_en);

  assert_cond_enable_R10: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && dsp_kind && is_cond) |-> (wr_en == (dc == cond_sense)));

  assert_idle_enable_R10: assert property (@(posedge clk) disable iff (rst)
    !retire_valid |-> !wr_en);

  assert_sw_priority_R11: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> sw_rdata[7:1] == $past(sw_wdata[7:1]));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!retire_valid && !sw_we) |=> $stable(sw_rdata));

endmodule

bind dsp_status_unit dsp_status_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .retire_valid (retire_valid),
  .instr_class  (instr_class),
  .is_cond      (is_cond),
  .cond_sense   (cond_sense),
  .alu_c        (alu_c),
  .alu_n        (alu_n),
  .alu_z        (alu_z),
  .alu_v        (alu_v),
  .sw_we        (sw_we),
  .sw_wdata     (sw_wdata),
  .sw_rdata     (sw_rdata),
  .dc           (dc),
  .wr_en        (wr_en)
);

// File: tb/dsp_status_unit_bench.sv
module dsp_status_unit_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       retire_valid = 1'b0;
  logic [1:0] instr_class = 2'b00;
  logic       is_cond = 1'b0;
  logic       cond_sense = 1'b0;
  logic       alu_c = 1'b0, alu_n = 1'b0, alu_z = 1'b0, alu_v = 1'b0;
  logic       sw_we = 1'b0;
  logic [7:0] sw_wdata = 8'h00;
  logic [7:0] sw_rdata;
  logic       dc;
  logic       wr_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dsp_status_unit u_dsp_status_unit (
    .clk(clk), .rst(rst), .retire_valid(retire_valid), .instr_class(instr_class),
    .is_cond(is_cond), .cond_sense(cond_sense), .alu_c(alu_c), .alu_n(alu_n),
    .alu_z(alu_z), .alu_v(alu_v), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .dc(dc), .wr_en(wr_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic exp_dc(input logic [2:0] s, input logic c, n, z, v);
    case (s)
      3'd0: return c;
      3'd1: return n;
      3'd2: return z;
      3'd3: return v;
      3'd4: return (n == v) && !z;
      3'd5: return (n == v);
      default: return 1'b0;
    endcase
  endfunction

  task automatic go_idle();
    retire_valid = 1'b0; instr_class = 2'b00; is_cond = 1'b0; cond_sense = 1'b0;
    alu_c = 1'b0; alu_n = 1'b0; alu_z = 1'b0; alu_v = 1'b0; sw_we = 1'b0;
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = d;
    @(posedge clk); #1;
    go_idle();
  endtask

  // drives an instruction at negedge; caller may check wr_en before the edge
  task automatic put_op(input logic [1:0] cl, input logic cnd, input logic sns,
                        input logic [3:0] f);
    @(negedge clk);
    retire_valid = 1'b1; instr_class = cl; is_cond = cnd; cond_sense = sns;
    {alu_v, alu_z, alu_n, alu_c} = f;
    #1;
  endtask

  task automatic finish_op();
    @(posedge clk); #1;
    go_idle();
  endtask

  task automatic t_reset();
    check("R1 reset register", sw_rdata, 8'h00);
    check("R1 reset dc", {7'd0, dc}, 8'h00);
    check("R10 idle wr_en", {7'd0, wr_en}, 8'h00);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] f;
        logic       e;
        string      tag;
        f = p[3:0];
        sw_write({s[2:0], 5'b0});
        put_op(2'b01, 1'b0, 1'b0, f);
        finish_op();
        e = exp_dc(s[2:0], f[0], f[1], f[2], f[3]);
        tag = (s >= 6) ? "R6 reserved select" : (s >= 4) ? "R5 signed compare" : "R4 flag select";
        check("R3 R2 flag load layout", sw_rdata[7:1], {s[2:0], f});
        check(tag, {7'd0, dc}, {7'd0, e});
      end
    end
  endtask

  task automatic t_hold();
    // select zero, v=1 z=0 n=1 c=0 -> dc 0
    sw_write(8'b010_1_0_1_0_0);
    check("R11 setup", sw_rdata, 8'b0101_0100);
    put_op(2'b10, 1'b0, 1'b0, 4'b1111);
    check("R10 uncond noflag wr_en", {7'd0, wr_en}, 8'h01);
    finish_op();
    check("R7 multiply/move holds", sw_rdata, 8'b0101_0100);
    put_op(2'b00, 1'b0, 1'b0, 4'b1111);
    finish_op();
    check("R8 CPU holds", sw_rdata, 8'b0101_0100);
    @(negedge clk); alu_z = 1'b1; alu_c = 1'b1;
    @(posedge clk); #1; go_idle();
    check("R12 idle holds", sw_rdata, 8'b0101_0100);
  endtask

  task automatic t_cond();
    // select zero, z=1 -> dc 1
    sw_write(8'b010_0_1_0_0_0);
    check("R11 dc recomputed", sw_rdata, 8'h49);
    put_op(2'b01, 1'b1, 1'b1, 4'b0000);
    check("R10 cond pass wr_en", {7'd0, wr_en}, 8'h01);
    finish_op();
    check("R9 cond pass holds", sw_rdata, 8'h49);
    put_op(2'b01, 1'b1, 1'b0, 4'b0000);
    check("R10 cond fail wr_en", {7'd0, wr_en}, 8'h00);
    finish_op();
    check("R9 cond fail holds", sw_rdata, 8'h49);
    put_op(2'b10, 1'b1, 1'b0, 4'b1011);
    check("R10 cond move fail wr_en", {7'd0, wr_en}, 8'h00);
    finish_op();
    check("R9 cond move holds", sw_rdata, 8'h49);
    put_op(2'b00, 1'b1, 1'b0, 4'b0000);
    check("R10 CPU not gated", {7'd0, wr_en}, 8'h01);
    finish_op();
    // make dc 0 by loading z=0, then check both senses again
    put_op(2'b01, 1'b0, 1'b0, 4'b0000);
    check("R10 uncond wr_en", {7'd0, wr_en}, 8'h01);
    finish_op();
    check("R4 dc cleared", sw_rdata, 8'h40);
    put_op(2'b01, 1'b1, 1'b0, 4'b0100);
    check("R10 sense0 dc0 wr_en", {7'd0, wr_en}, 8'h01);
    finish_op();
    check("R9 cond holds dc0", sw_rdata, 8'h40);
    put_op(2'b01, 1'b1, 1'b1, 4'b0100);
    check("R10 sense1 dc0 wr_en", {7'd0, wr_en}, 8'h00);
    finish_op();
  endtask

  task automatic t_priority();
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = 8'b110_1_1_1_1_1;
    retire_valid = 1'b1; instr_class = 2'b01; {alu_v, alu_z, alu_n, alu_c} = 4'b0000;
    @(posedge clk); #1; go_idle();
    check("R11 sw wins, bit0 ignored", sw_rdata, 8'b1101_1110);
    check("R6 reserved forces dc 0", {7'd0, dc}, 8'h00);
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = 8'b000_0_0_0_1_0;
    retire_valid = 1'b1; instr_class = 2'b01; {alu_v, alu_z, alu_n, alu_c} = 4'b1110;
    @(posedge clk); #1; go_idle();
    check("R11 sw wins, dc from written carry", sw_rdata, 8'h03);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset();
    t_sweep();
    t_hold();
    t_cond();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule